// File: doc/BRIEF.md
# Security-Aware Coprocessor-Access Control Register Gate

This block sits beside a core's system-register decode path and owns a single 32-bit control register: the one that sets which coprocessors non-secure software may use. Each cycle it may receive one system-register request, made up of the selector fields, a read/write flag, the current exception level, the secure-state flag and write data. If the selector names this register, the block decides whether the access is allowed, is trapped to the highest exception level (EL3), or is treated as an undefined instruction. For an allowed read it returns the read data.

Three static configuration inputs set how the register behaves. They say whether EL3 is implemented, whether EL3 runs in the 64-bit state, and whether the core follows the newer architecture version. Depending on these inputs the register is a stored read/write register, a read-only constant of 0xC00, or absent. Exception entry and all other system registers are handled elsewhere. The block reports its verdict and nothing more.

Top module: `sreg_access_check`

## Requirements
- R1: The block responds only to a request with `req_valid` high whose selector is coprocessor 15, opc1 0, CRn 1, CRm 1 and opc2 2. Any other request, or an idle cycle, raises no result output and leaves the stored register unchanged.
- R2: Each responding request raises exactly one of `rsp_ok`, `rsp_trap_el3` and `rsp_undef`. That output is a one-cycle pulse on the cycle after the request.
- R3: A request made at EL0 (`req_el` = 0) is always undefined.
- R4: With EL3 present in the 64-bit state, any access from EL3 (`req_el` = 3) is OK. A read returns 0xC00. A write changes no stored state.
- R5: With EL3 present in the 64-bit state, any access from secure EL1 or secure EL2 (`req_secure` = 1) raises trap-to-EL3.
- R6: With EL3 present in the 64-bit state, a non-secure read from EL1 or EL2 is OK and returns 0xC00. A non-secure write from EL1 or EL2 is undefined.
- R7: With EL3 present in the 32-bit state, EL3 may read and write the stored register, and a read returns the stored value. After reset the stored value is 0.
- R8: With EL3 present in the 32-bit state, a read from EL1 or EL2 is OK in either security state and returns the stored value. A write from EL1 or EL2 is undefined.
- R9: With EL3 absent on the newer architecture version, a read from EL1 or EL2 is OK and returns 0xC00. Any write, and any request at EL3, is undefined.
- R10: With EL3 absent on the older architecture version, every responding request is undefined.
- R11: `rsp_rdata` is zero whenever `rsp_ok` is low, and also on the response to a successful write.
- R12: Write data enters the stored register only on a write that is OK with EL3 present in the 32-bit state. Every other request leaves the stored value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_cp | input | 4 | Coprocessor number |
| req_opc1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register field |
| req_crm | input | 4 | Secondary register field |
| req_opc2 | input | 3 | Second opcode field |
| req_write | input | 1 | 1 = write, 0 = read |
| req_el | input | 2 | Current exception level, 0 to 3 |
| req_secure | input | 1 | Requester is in the secure state |
| req_wdata | input | 32 | Write data |
| cfg_has_el3 | input | 1 | EL3 is implemented |
| cfg_el3_wide | input | 1 | EL3 runs in the 64-bit state |
| cfg_newer_arch | input | 1 | Core follows the newer architecture version |
| rsp_rdata | output | 32 | Read data for an OK read, otherwise zero |
| rsp_ok | output | 1 | Access allowed (pulse) |
| rsp_trap_el3 | output | 1 | Access traps to EL3 (pulse) |
| rsp_undef | output | 1 | Access is an undefined instruction (pulse) |

## Verification
Every result is registered once, so the verdict and the read data for a request are due exactly one clock after the edge that samples the request. A write is visible to a read issued on the following cycle. The bench drives each request on a falling edge, queues the expected verdict and data from its own model of the requirements, and compares the outputs on the next falling edge, so every comparison lands in that single due cycle. Idle and non-matching cycles are compared in the same way, which also shows that the result outputs are pulses and not held levels. Stored-state effects are confirmed by reading the register back through the normal request path.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   typedef enum logic [1:0] {
      VERDICT_NONE  = 2'd0,
      VERDICT_OK    = 2'd1,
      VERDICT_TRAP  = 2'd2,
      VERDICT_UNDEF = 2'd3
   } verdict_e;

   typedef enum logic [1:0] {
      RD_ZERO  = 2'd0,
      RD_CONST = 2'd1,
      RD_STORE = 2'd2
   } rd_src_e;

   localparam logic [1:0] LVL_0 = 2'd0;
   localparam logic [1:0] LVL_3 = 2'd3;

endpackage

// File: rtl/sreg_sel_decode.sv
module sreg_sel_decode #(
   parameter int          CP_W    = 4,
   parameter int          OPC1_W  = 3,
   parameter int          CRN_W   = 4,
   parameter int          CRM_W   = 4,
   parameter int          OPC2_W  = 3,
   parameter logic [CP_W-1:0]   HIT_CP   = 4'd15,
   parameter logic [OPC1_W-1:0] HIT_OPC1 = 3'd0,
   parameter logic [CRN_W-1:0]  HIT_CRN  = 4'd1,
   parameter logic [CRM_W-1:0]  HIT_CRM  = 4'd1,
   parameter logic [OPC2_W-1:0] HIT_OPC2 = 3'd2
) (
   input  logic [CP_W-1:0]   cp,
   input  logic [OPC1_W-1:0] opc1,
   input  logic [CRN_W-1:0]  crn,
   input  logic [CRM_W-1:0]  crm,
   input  logic [OPC2_W-1:0] opc2,
   output logic              hit
);
   localparam int N_FIELDS = 5;

   logic [N_FIELDS-1:0] field_eq;

   assign field_eq[0] = (cp   == HIT_CP);
   assign field_eq[1] = (opc1 == HIT_OPC1);
   assign field_eq[2] = (crn  == HIT_CRN);
   assign field_eq[3] = (crm  == HIT_CRM);
   assign field_eq[4] = (opc2 == HIT_OPC2);

   assign hit = &field_eq;
endmodule

// File: rtl/sreg_policy.sv
module sreg_policy
   import sreg_pkg::*;
(
   input  logic     req_on,
   input  logic     is_write,
   input  logic [1:0] lvl,
   input  logic     secure,
   input  logic     has_el3,
   input  logic     el3_wide,
   input  logic     newer_arch,
   output verdict_e verdict,
   output rd_src_e  rd_src,
   output logic     store_we
);
   always_comb begin
      verdict  = VERDICT_NONE;
      rd_src   = RD_ZERO;
      store_we = 1'b0;
      if (req_on) begin
         if (lvl == LVL_0) begin
            verdict = VERDICT_UNDEF;
         end else if (has_el3 && el3_wide) begin
            if (lvl == LVL_3) begin
               verdict = VERDICT_OK;
               rd_src  = is_write ? RD_ZERO : RD_CONST;
            end else if (secure) begin
               verdict = VERDICT_TRAP;
            end else if (!is_write) begin
               verdict = VERDICT_OK;
               rd_src  = RD_CONST;
            end else begin
               verdict = VERDICT_UNDEF;
            end
         end else if (has_el3) begin
            if (lvl == LVL_3) begin
               verdict  = VERDICT_OK;
               store_we = is_write;
               rd_src   = is_write ? RD_ZERO : RD_STORE;
            end else if (!is_write) begin
               verdict = VERDICT_OK;
               rd_src  = RD_STORE;
            end else begin
               verdict = VERDICT_UNDEF;
            end
         end else if (newer_arch && (lvl != LVL_3) && !is_write) begin
            verdict = VERDICT_OK;
            rd_src  = RD_CONST;
         end else begin
            verdict = VERDICT_UNDEF;
         end
      end
   end
endmodule

// File: rtl/sreg_store.sv
module sreg_store #(
   parameter int              DATA_W    = 32,
   parameter logic [DATA_W-1:0] RST_VAL = '0,
   parameter bit              ASYNC_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   generate
      if (ASYNC_RST) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= RST_VAL;
            else if (we) q <= d;
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n)  q <= RST_VAL;
            else if (we) q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/sreg_access_check.sv
module sreg_access_check
   import sreg_pkg::*;
#(
   parameter int                DATA_W    = 32,
   parameter int                CP_W      = 4,
   parameter int                OPC1_W    = 3,
   parameter int                CRN_W     = 4,
   parameter int                CRM_W     = 4,
   parameter int                OPC2_W    = 3,
   parameter logic [DATA_W-1:0] CONST_VAL = 32'h0000_0C00,
   parameter logic [DATA_W-1:0] RST_VAL   = '0,
   parameter bit                ASYNC_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CP_W-1:0]   req_cp,
   input  logic [OPC1_W-1:0] req_opc1,
   input  logic [CRN_W-1:0]  req_crn,
   input  logic [CRM_W-1:0]  req_crm,
   input  logic [OPC2_W-1:0] req_opc2,
   input  logic              req_write,
   input  logic [1:0]        req_el,
   input  logic              req_secure,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              cfg_has_el3,
   input  logic              cfg_el3_wide,
   input  logic              cfg_newer_arch,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_ok,
   output logic              rsp_trap_el3,
   output logic              rsp_undef
);
   localparam int MIN_DATA_W = 12;

   generate
      if (DATA_W < MIN_DATA_W) begin : g_bad_width
         $error("sreg_access_check: DATA_W must hold the constant value");
      end
      if (CP_W < 4 || CRN_W < 1 || CRM_W < 1 || OPC1_W < 1 || OPC2_W < 2) begin : g_bad_sel
         $error("sreg_access_check: selector fields too narrow for match values");
      end
   endgenerate

   logic              sel_hit;
   verdict_e          verdict;
   rd_src_e           rd_src;
   logic              store_we;
   logic [DATA_W-1:0] store_q;
   logic [DATA_W-1:0] rd_next;

   sreg_sel_decode #(
      .CP_W   (CP_W),   .OPC1_W (OPC1_W), .CRN_W (CRN_W),
      .CRM_W  (CRM_W),  .OPC2_W (OPC2_W),
      .HIT_CP   (CP_W'(15)),  .HIT_OPC1 (OPC1_W'(0)), .HIT_CRN (CRN_W'(1)),
      .HIT_CRM  (CRM_W'(1)),  .HIT_OPC2 (OPC2_W'(2))
   ) u_dec (
      .cp   (req_cp),
      .opc1 (req_opc1),
      .crn  (req_crn),
      .crm  (req_crm),
      .opc2 (req_opc2),
      .hit  (sel_hit)
   );

   sreg_policy u_pol (
      .req_on     (req_valid && sel_hit),
      .is_write   (req_write),
      .lvl        (req_el),
      .secure     (req_secure),
      .has_el3    (cfg_has_el3),
      .el3_wide   (cfg_el3_wide),
      .newer_arch (cfg_newer_arch),
      .verdict    (verdict),
      .rd_src     (rd_src),
      .store_we   (store_we)
   );

   sreg_store #(
      .DATA_W    (DATA_W),
      .RST_VAL   (RST_VAL),
      .ASYNC_RST (ASYNC_RST)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (store_we),
      .d     (req_wdata),
      .q     (store_q)
   );

   always_comb begin
      unique case (rd_src)
         RD_CONST: rd_next = CONST_VAL;
         RD_STORE: rd_next = store_q;
         default:  rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_ok       <= 1'b0;
         rsp_trap_el3 <= 1'b0;
         rsp_undef    <= 1'b0;
         rsp_rdata    <= '0;
      end else begin
         rsp_ok       <= (verdict == VERDICT_OK);
         rsp_trap_el3 <= (verdict == VERDICT_TRAP);
         rsp_undef    <= (verdict == VERDICT_UNDEF);
         rsp_rdata    <= (verdict == VERDICT_OK) ? rd_next : '0;
      end
   end
endmodule

// File: rtl/sreg_access_check_sva.sv
module sreg_access_check_sva #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [3:0]        req_cp,
   input logic [2:0]        req_opc1,
   input logic [3:0]        req_crn,
   input logic [3:0]        req_crm,
   input logic [2:0]        req_opc2,
   input logic [1:0]        req_el,
   input logic              req_secure,
   input logic              cfg_has_el3,
   input logic              cfg_el3_wide,
   input logic              cfg_newer_arch,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              rsp_ok,
   input logic              rsp_trap_el3,
   input logic              rsp_undef
);
   logic req_hit;
   assign req_hit = req_valid && req_cp == 4'd15 && req_opc1 == 3'd0 &&
                    req_crn == 4'd1 && req_crm == 4'd1 && req_opc2 == 3'd2;

   assert_single_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_hit |=> $countones({rsp_ok, rsp_trap_el3, rsp_undef}) == 1);

   assert_results_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_ok, rsp_trap_el3, rsp_undef}));

   assert_quiet_on_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_hit |=> !(rsp_ok || rsp_trap_el3 || rsp_undef));

   assert_el0_undef_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_hit && req_el == 2'd0) |=> rsp_undef);

   assert_secure_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_hit && cfg_has_el3 && cfg_el3_wide && req_secure &&
       (req_el == 2'd1 || req_el == 2'd2)) |=> rsp_trap_el3);

   assert_absent_old_undef_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_hit && !cfg_has_el3 && !cfg_newer_arch) |=> rsp_undef);

   assert_rdata_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_ok |-> rsp_rdata == '0);
endmodule

bind sreg_access_check sreg_access_check_sva #(.DATA_W(DATA_W)) u_sva (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_cp         (req_cp),
   .req_opc1       (req_opc1),
   .req_crn        (req_crn),
   .req_crm        (req_crm),
   .req_opc2       (req_opc2),
   .req_el         (req_el),
   .req_secure     (req_secure),
   .cfg_has_el3    (cfg_has_el3),
   .cfg_el3_wide   (cfg_el3_wide),
   .cfg_newer_arch (cfg_newer_arch),
   .rsp_rdata      (rsp_rdata),
   .rsp_ok         (rsp_ok),
   .rsp_trap_el3   (rsp_trap_el3),
   .rsp_undef      (rsp_undef)
);

// File: tb/tb_sreg_access_check.sv
`timescale 1ns/1ps
module tb_sreg_access_check;
   localparam logic [31:0] CONST_RD = 32'h0000_0C00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_cp = '0;
   logic [2:0]  req_opc1 = '0;
   logic [3:0]  req_crn = '0;
   logic [3:0]  req_crm = '0;
   logic [2:0]  req_opc2 = '0;
   logic        req_write = 1'b0;
   logic [1:0]  req_el = '0;
   logic        req_secure = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        cfg_has_el3 = 1'b1;
   logic        cfg_el3_wide = 1'b0;
   logic        cfg_newer_arch = 1'b1;
   logic [31:0] rsp_rdata;
   logic        rsp_ok, rsp_trap_el3, rsp_undef;

   int checks = 0;
   int failures = 0;
   logic [31:0] model_reg = 32'h0;

   typedef struct {
      logic [2:0]  res;
      logic [31:0] data;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   always #2 clk = ~clk;

   sreg_access_check dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .req_cp(req_cp), .req_opc1(req_opc1), .req_crn(req_crn),
      .req_crm(req_crm), .req_opc2(req_opc2), .req_write(req_write),
      .req_el(req_el), .req_secure(req_secure), .req_wdata(req_wdata),
      .cfg_has_el3(cfg_has_el3), .cfg_el3_wide(cfg_el3_wide),
      .cfg_newer_arch(cfg_newer_arch), .rsp_rdata(rsp_rdata),
      .rsp_ok(rsp_ok), .rsp_trap_el3(rsp_trap_el3), .rsp_undef(rsp_undef)
   );

   // Reference model: result code {ok,trap,undef} and data, from the requirements.
   task automatic predict(input logic hit, input logic wr, input logic [1:0] el,
                          input logic sec, input logic [31:0] wd, input string tag);
      exp_t e;
      e.res = 3'b000; e.data = 32'h0; e.tag = tag;
      if (hit) begin
         if (el == 0) e.res = 3'b001;
         else if (cfg_has_el3 && cfg_el3_wide) begin
            if (el == 3) begin e.res = 3'b100; e.data = wr ? 32'h0 : CONST_RD; end
            else if (sec) e.res = 3'b010;
            else if (!wr) begin e.res = 3'b100; e.data = CONST_RD; end
            else e.res = 3'b001;
         end else if (cfg_has_el3) begin
            if (el == 3) begin
               e.res = 3'b100;
               e.data = wr ? 32'h0 : model_reg;
               if (wr) model_reg = wd;
            end else if (!wr) begin e.res = 3'b100; e.data = model_reg; end
            else e.res = 3'b001;
         end else if (cfg_newer_arch && el != 3 && !wr) begin
            e.res = 3'b100; e.data = CONST_RD;
         end else e.res = 3'b001;
      end
      exp_q.push_back(e);
   endtask

   task automatic compare();
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if ({rsp_ok, rsp_trap_el3, rsp_undef} !== e.res || rsp_rdata !== e.data) begin
         failures++;
         $display("FAIL %s: got res=%b data=%h, expected res=%b data=%h",
                  e.tag, {rsp_ok, rsp_trap_el3, rsp_undef}, rsp_data_fix(rsp_rdata),
                  e.res, e.data);
      end
   endtask

   function automatic logic [31:0] rsp_data_fix(input logic [31:0] v);
      return v;
   endfunction

   // Drive one request on a falling edge, compare on the next falling edge.
   task automatic raw(input string tag, input logic v, input logic [2:0] op2,
                      input logic wr, input logic [1:0] el, input logic sec,
                      input logic [31:0] wd);
      req_valid = v; req_cp = 4'd15; req_opc1 = 3'd0; req_crn = 4'd1;
      req_crm = 4'd1; req_opc2 = op2; req_write = wr; req_el = el;
      req_secure = sec; req_wdata = wd;
      predict(v && op2 == 3'd2, wr, el, sec, wd, tag);
      @(negedge clk);
      compare();
   endtask

   task automatic acc(input string tag, input logic wr, input logic [1:0] el,
                      input logic sec, input logic [31:0] wd);
      raw(tag, 1'b1, 3'd2, wr, el, sec, wd);
   endtask

   task automatic idle(input string tag);
      raw(tag, 1'b0, 3'd2, 1'b0, 2'd3, 1'b0, 32'h0);
   endtask

   initial begin
      #(200000 * 4);
      failures++;
      $display("FAIL watchdog: got no end, expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if ({rsp_ok, rsp_trap_el3, rsp_undef, rsp_rdata} !== 35'h0) begin
         failures++;
         $display("FAIL R2 reset: got %b/%h, expected 000/0",
                  {rsp_ok, rsp_trap_el3, rsp_undef}, rsp_rdata);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // 32-bit EL3 configuration
      cfg_has_el3 = 1; cfg_el3_wide = 0; cfg_newer_arch = 1;
      acc("R7 reset value read at EL3", 0, 3, 1, 0);
      acc("R12 write at EL3", 1, 3, 1, 32'hA5A5_1234);
      acc("R8 NS EL1 read of stored value", 0, 1, 0, 0);
      acc("R8 EL2 write undefined", 1, 2, 0, 32'h0000_FFFF);
      acc("R12 value unchanged after rejected write", 0, 3, 0, 0);
      acc("R3 EL0 read undefined", 0, 0, 0, 0);
      raw("R1 non-matching selector write", 1, 3'd3, 1, 3, 1, 32'h0);
      raw("R1 idle cycle with write fields", 0, 3'd2, 1, 3, 1, 32'h1111_0000);
      acc("R1 stored value unchanged after misses", 0, 3, 1, 0);
      acc("R8 secure EL1 read", 0, 1, 1, 0);
      acc("R7 second write at EL3", 1, 3, 0, 32'h0000_0C0F);
      acc("R7 read back second write", 0, 3, 0, 0);
      idle("R2 result is a single-cycle pulse");

      // 64-bit EL3 configuration
      cfg_el3_wide = 1;
      acc("R4 EL3 read returns constant", 0, 3, 1, 0);
      acc("R4 EL3 write accepted", 1, 3, 1, 32'hDEAD_BEEF);
      acc("R5 secure EL1 read traps", 0, 1, 1, 0);
      acc("R5 secure EL2 write traps", 1, 2, 1, 32'h1);
      acc("R6 NS EL1 read constant", 0, 1, 0, 0);
      acc("R6 NS EL2 read constant", 0, 2, 0, 0);
      acc("R6 NS EL2 write undefined", 1, 2, 0, 32'h2);
      acc("R3 secure EL0 undefined", 1, 0, 1, 32'h3);
      acc("R11 undefined response data zero", 1, 1, 0, 32'h4);

      // back to 32-bit: constant-mode writes left state alone
      cfg_el3_wide = 0;
      acc("R4 R12 stored value untouched by 64-bit mode", 0, 3, 0, 0);

      // EL3 absent, newer architecture
      cfg_has_el3 = 0; cfg_newer_arch = 1;
      acc("R9 EL1 read constant", 0, 1, 0, 0);
      acc("R9 EL2 read constant", 0, 2, 1, 0);
      acc("R9 EL1 write undefined", 1, 1, 0, 32'h5);
      acc("R9 EL3 request undefined", 0, 3, 0, 0);

      // EL3 absent, older architecture
      cfg_newer_arch = 0;
      acc("R10 EL1 read undefined", 0, 1, 0, 0);
      acc("R10 EL2 write undefined", 1, 2, 0, 32'h6);
      acc("R10 EL3 read undefined", 0, 3, 1, 0);
      idle("R2 quiet after last request");

      // confirm the stored value survived the absent modes
      cfg_has_el3 = 1; cfg_newer_arch = 1;
      acc("R12 stored value after absent modes", 0, 2, 0, 0);
      idle("R1 final idle");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule